// File: doc/BRIEF.md
# Programmable Reload Down-Counter Timer

This block is a 16-bit timer that counts down at a rate derived from the system clock. Software controls it through a byte-wide register port with three addresses. A control byte enables the counter, picks one of four prescale ratios, and carries a strobe bit that reloads the counter and restarts it. Two data addresses have a dual role. A write to them sets the low or high byte of the 16-bit reload value. A read from them returns the matching byte of the live count.

When the count is zero and a prescaled tick arrives, the counter takes the reload value again and raises a sticky terminal-count flag. That flag drives the interrupt output. Reading the control byte clears the flag.

To get a coherent 16-bit read while the counter runs, software reads the low byte first. That read captures the high count byte into a holding register, and the next high-byte read returns the captured value.

Top module: `reload_timer`

## Requirements
- R1: After reset the control byte (address 0) reads 00h, both count bytes (addresses 1 and 2) read 00h, and `tc_irq` is 0.
- R2: Control bits [3:2] select the tick rate. 00 gives one decrement per 4 clocks, 01 per 16, 10 per 64 and 11 per 256. The prescaler starts from zero, so the first decrement comes a full period after enable or restart.
- R3: With control bit 0 (enable) at 0 the count holds its value for any number of clocks.
- R4: Writing control bit 1 = 1 loads the reload value into the counter on the clock edge after the write, whether or not the timer is enabled. Bit 1 always reads back as 0. A tick in the cycle between the write and the load is discarded.
- R5: A read of address 1 returns count[7:0] and captures count[15:8]. A later read of address 2 returns the captured byte, even if the count has changed since.
- R6: Reading any address leaves counting unaffected: the count sequence is the same with or without reads.
- R7: Writes to address 1 and address 2 set reload[7:0] and reload[15:8] and do not change the count that those addresses read back.
- R8: A tick while the count is 0 reloads the counter and sets the terminal-count flag. The flag reads as control bit 7 and drives `tc_irq` high.
- R9: A read of the control byte clears the terminal-count flag one clock later, unless a new terminal event occurs in that same cycle.
- R10: Clearing the enable bit resets the prescaler. After enable is set again, the first decrement comes a full prescale period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 2 | Register address: 0 control, 1 count/reload low, 2 count/reload high |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_rd | input | 1 | Read strobe, one clock per read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the addressed register |
| tc_irq | output | 1 | Terminal-count interrupt, high while the sticky flag is set |

## Verification
Read data is combinational, so a read returns state as it stood after the edges before the read cycle. Capturing, flag clearing and control or reload updates land on the edge that closes the access. A restart loads the counter one edge after that, and the first decrement then follows a full prescale period later. The bench counts edges from the end of each write. It places reads in the middle of a prescale period where that is possible. Where a boundary is the point of the check, it places the read exactly on the decrement edge. Interrupt checks are sampled one time unit after the falling edge that follows the edge where the flag changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_HI   = 2'd2;

  localparam int unsigned CB_EN      = 0;
  localparam int unsigned CB_RESTART = 1;
  localparam int unsigned CB_DIV     = 2;
  localparam int unsigned CB_FLAG    = 7;

  typedef enum logic [1:0] {
    DIV4   = 2'b00,
    DIV16  = 2'b01,
    DIV64  = 2'b10,
    DIV256 = 2'b11
  } div_sel_e;

  // prescaler width must cover the largest ratio
  localparam int unsigned PSC_W = 8;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PW = PSC_W
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  input  logic     clear_i,
  input  div_sel_e div_i,
  output logic     tick_o
);
  logic [PW-1:0] psc_q, psc_d;
  logic [PW-1:0] mask;

  function automatic logic [PW-1:0] ratio_mask(input div_sel_e s);
    logic [PW:0] one_hot;
    one_hot = (PW+1)'(1) << (2 * int'(s) + 2);
    return PW'(one_hot - (PW+1)'(1));
  endfunction

  assign mask = ratio_mask(div_i);

  always_comb begin
    if (!run_i || clear_i) psc_d = '0;
    else                   psc_d = psc_q + PW'(1);
  end

  assign tick_o = run_i && !clear_i && ((psc_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // R10
  psc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (psc_q == '0));

  // R3
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> run_i);
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] count_o,
  output logic          terminal_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          term_d;

  always_comb begin
    cnt_d  = cnt_q;
    term_d = 1'b0;
    if (load_i) begin
      cnt_d = reload_i;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_d  = reload_i;
        term_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o    = cnt_q;
  assign terminal_o = term_d;

  // R4
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(reload_i)));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

  // R8
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)));

  // R8
  term_only_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terminal_o |-> (cnt_q == '0 && tick_i));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [CW-1:0]     count_i,
  input  logic              terminal_i,
  output logic              en_o,
  output div_sel_e          div_o,
  output logic              restart_o,
  output logic [CW-1:0]     reload_o,
  output logic              flag_o
);
  localparam int unsigned HB = CW - BYTE_W;

  logic              en_q, en_d;
  div_sel_e          div_q, div_d;
  logic              rst_q, rst_d;
  logic [CW-1:0]     rel_q, rel_d;
  logic [HB-1:0]     hold_q, hold_d;
  logic              flag_q, flag_d;

  logic wr_ctrl, wr_lo, wr_hi, rd_ctrl, rd_lo;

  assign wr_ctrl = wr_i && (addr_i == ADR_CTRL);
  assign wr_lo   = wr_i && (addr_i == ADR_LO);
  assign wr_hi   = wr_i && (addr_i == ADR_HI);
  assign rd_ctrl = rd_i && (addr_i == ADR_CTRL);
  assign rd_lo   = rd_i && (addr_i == ADR_LO);

  always_comb begin
    en_d   = en_q;
    div_d  = div_q;
    rst_d  = 1'b0;
    rel_d  = rel_q;
    hold_d = hold_q;
    flag_d = flag_q;
    if (wr_ctrl) begin
      en_d  = wdata_i[CB_EN];
      div_d = div_sel_e'(wdata_i[CB_DIV +: 2]);
      rst_d = wdata_i[CB_RESTART];
    end
    if (wr_lo) rel_d[BYTE_W-1:0] = wdata_i;
    if (wr_hi) rel_d[CW-1:BYTE_W] = wdata_i[HB-1:0];
    if (rd_lo) hold_d = count_i[CW-1:BYTE_W];
    if (rd_ctrl) flag_d = 1'b0;
    if (terminal_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= DIV4;
      rst_q  <= 1'b0;
      rel_q  <= '0;
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      div_q  <= div_d;
      rst_q  <= rst_d;
      rel_q  <= rel_d;
      hold_q <= hold_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_CTRL: begin
        rdata_o[CB_EN]         = en_q;
        rdata_o[CB_DIV +: 2]   = div_q;
        rdata_o[CB_FLAG]       = flag_q;
      end
      ADR_LO:   rdata_o = count_i[BYTE_W-1:0];
      ADR_HI:   rdata_o = BYTE_W'(hold_q);
      default:  rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign div_o     = div_q;
  assign restart_o = rst_q;
  assign reload_o  = rel_q;
  assign flag_o    = flag_q;

  // R5
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (hold_q == $past(count_i[CW-1:BYTE_W])));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !terminal_i) |=> !flag_q);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terminal_i |=> flag_q);

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> (!rst_q || $past(wr_ctrl)));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        tc_irq
);
  logic             rstn_i;
  logic             en;
  div_sel_e         div;
  logic             restart;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             tick;
  logic             terminal;
  logic             flag;

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rstn_i)
  );

  tmr_regs #(.CW(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rstn_i),
    .addr_i     (reg_addr),
    .wr_i       (reg_wr),
    .rd_i       (reg_rd),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .count_i    (count),
    .terminal_i (terminal),
    .en_o       (en),
    .div_o      (div),
    .restart_o  (restart),
    .reload_o   (reload),
    .flag_o     (flag)
  );

  tmr_prescaler #(.PW(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rstn_i),
    .run_i   (en),
    .clear_i (restart),
    .div_i   (div),
    .tick_o  (tick)
  );

  tmr_downcount #(.CW(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rstn_i),
    .tick_i     (tick),
    .load_i     (restart),
    .reload_i   (reload),
    .count_o    (count),
    .terminal_o (terminal)
  );

  assign tc_irq = flag;

  // R6
  read_no_effect_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    (reg_rd && !tick && !restart) |=> $stable(count));
endmodule

// File: tb/reload_timer_tb.sv
`timescale 1ns/100ps
module reload_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       tc_irq;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  exp_t cur;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  reload_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tc_irq    (tc_irq)
  );

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  // driver: pushes the expected byte, then issues the read
  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    exp_q.push_back('{val: e, tag: tag});
    @(negedge clk);
    reg_rd   = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string tag);
    #1;
    n_chk++;
    if (tc_irq !== e) begin
      n_bad++;
      $display("FAIL %s tc_irq actual=%0b expected=%0b", tag, tc_irq, e);
    end
  endtask

  // monitor: compares each read result against the queue head
  always @(negedge clk) begin
    #1;
    if (reg_rd === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL scoreboard read with empty queue actual=%02h expected=none", reg_rdata);
      end else begin
        cur = exp_q.pop_front();
        n_chk++;
        if (reg_rdata !== cur.val) begin
          n_bad++;
          $display("FAIL %s read actual=%02h expected=%02h", cur.tag, reg_rdata, cur.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, 8'h00, "R1");
    bus_read(2'd1, 8'h00, "R1");
    bus_read(2'd2, 8'h00, "R1");
    check_irq(1'b0, "R1");

    // R7 reload writes do not show on the read side
    bus_write(2'd1, 8'h34);
    bus_write(2'd2, 8'h12);
    bus_read(2'd1, 8'h00, "R7");
    bus_read(2'd2, 8'h00, "R7");

    // R4 restart while disabled
    bus_write(2'd0, 8'h02);
    bus_read(2'd1, 8'h34, "R4");
    bus_read(2'd2, 8'h12, "R4");
    bus_read(2'd0, 8'h00, "R4");
    // R3 disabled count holds
    repeat (50) @(negedge clk);
    bus_read(2'd1, 8'h34, "R3");

    // R2 divide by 4 from enable, decrements at k=4,8
    bus_write(2'd0, 8'h01);
    repeat (9) @(negedge clk);
    bus_read(2'd1, 8'h32, "R2");
    bus_read(2'd2, 8'h12, "R5");

    // R2 divide by 16 with restart: k'=56 -> 3 decrements
    bus_write(2'd0, 8'h07);
    repeat (56) @(negedge clk);
    bus_read(2'd1, 8'h31, "R2");

    // R2 divide by 64: k'=160 -> 2 decrements
    bus_write(2'd0, 8'h0B);
    repeat (160) @(negedge clk);
    bus_read(2'd1, 8'h32, "R2");

    // R2 divide by 256: k'=384 -> 1 decrement
    bus_write(2'd0, 8'h0F);
    repeat (384) @(negedge clk);
    bus_read(2'd1, 8'h33, "R2");

    // R6 back-to-back reads, div4 boundaries at k'=4,8
    bus_write(2'd0, 8'h03);
    bus_read(2'd1, 8'h34, "R6");
    bus_read(2'd1, 8'h34, "R6");
    bus_read(2'd1, 8'h33, "R6");
    bus_read(2'd1, 8'h33, "R6");
    bus_read(2'd1, 8'h32, "R6");

    // R5 coherent read across 0100h -> 00FFh
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h01);
    bus_write(2'd0, 8'h03);
    repeat (3) @(negedge clk);
    bus_read(2'd1, 8'h00, "R5");
    bus_read(2'd2, 8'h01, "R5");
    bus_read(2'd1, 8'hFF, "R5");
    bus_read(2'd2, 8'h00, "R5");

    // R8 terminal count from reload 2 at div4
    bus_write(2'd1, 8'h02);
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'h03);
    repeat (11) @(negedge clk);
    bus_read(2'd1, 8'h00, "R8");
    check_irq(1'b1, "R8");
    bus_read(2'd1, 8'h02, "R8");
    bus_read(2'd0, 8'h81, "R8");
    // R9 control read cleared the flag
    check_irq(1'b0, "R9");
    bus_read(2'd0, 8'h01, "R9");

    // R10 prescaler clears while disabled
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h50);
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'h02);
    bus_write(2'd0, 8'h01);
    repeat (5) @(negedge clk);
    bus_read(2'd1, 8'h4F, "R10");
    bus_write(2'd0, 8'h00);
    repeat (5) @(negedge clk);
    bus_read(2'd1, 8'h4E, "R3");
    bus_write(2'd0, 8'h01);
    repeat (2) @(negedge clk);
    bus_read(2'd1, 8'h4E, "R10");
    bus_read(2'd1, 8'h4D, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule